// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM and takes the memory from power-on to a usable state. When reset is released it raises clock enable at once. It then keeps the command bus at NOP for a power-up pause. The pause length in cycles is the clock frequency in MHz times the pause length in microseconds, which is 200 us by default.

After the pause the block issues a fixed sequence of commands. First comes a precharge of all banks. Then come a normal mode register load, an extended mode register load and a configurable number of auto-refresh commands. A parameter places the refresh group either before or after the two mode loads. Every command is followed by a parameterized gap of NOP cycles: tRP after a precharge, tRC after a refresh and tMRD after a mode load. When the gap after the last command ends, the block raises `init_done`. That flag stays high until reset, and the normal controller then takes over the bus.

Both register values are parameters. The bank address pins select which register a mode load writes.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs are held as follows: `sd_cke` low, the command pins at NOP, `sd_addr` and `sd_ba` zero, and `init_done` low.
- R2: `sd_cke` goes high in the first cycle after reset and stays high. No command other than NOP appears unless `sd_cke` was high in the cycle before.
- R3: The command pins are {cs_n,ras_n,cas_n,we_n}, with NOP = 0111. After reset the pins carry NOP for PWR_CYC-1 cycles, where PWR_CYC = CLK_MHZ*WAIT_US. A precharge (0010) follows in cycle PWR_CYC counted from the first clock edge after reset. During that precharge, `sd_addr` bit AP_BIT (10) is 1, all other address bits are 0, and `sd_ba` is 0.
- R4: The normal mode load is 0000 with `sd_ba`=0 and `sd_addr`=MODE_VAL. The extended mode load is 0000 with `sd_ba`=EXT_BA (2) and `sd_addr`=EXT_MODE_VAL. Both loads come after the precharge, and the normal load comes before the extended one.
- R5: Exactly NUM_REFRESH auto-refresh commands (0001) are issued, with `sd_addr` and `sd_ba` at 0, and consecutive refreshes are T_RC cycles apart.
- R6: With REFRESH_FIRST=0 the two mode loads directly follow the precharge and the refreshes come last. With REFRESH_FIRST=1 the refreshes directly follow the precharge and the mode loads come last.
- R7: The next command comes T_RP cycles after a precharge, T_RC cycles after a refresh and T_MRD cycles after a mode load. Every cycle in between carries NOP, so a mode load is always followed by NOP (T_MRD ≥ 2).
- R8: `init_done` rises exactly one gap (the one that belongs to the last command) after the last command. From then on it stays high with the bus at NOP until reset.
- R9: Asserting `rst` at any point in the sequence returns the block to the R1 state. The full pause and sequence are then repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also driven to the memory |
| rst | input | 1 | Synchronous active-high reset |
| init_done | output | 1 | High once initialization is complete |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins; carry register values during mode loads |
| sd_ba | output | BA_W | Bank address; selects normal or extended register on a mode load |

## Verification
The bench runs two copies side by side, one with each refresh placement, and compares every cycle against a table of expected commands. A design with an off-by-one pause or gap therefore shows a command one cycle early or late. A design with a swapped order shows a refresh where a mode load should be. A design that forgets the all-banks bit or the bank select for the extended register shows a wrong address or bank value. The bench also checks that the done flag rises in exactly one cycle and then holds. Finally, it pulls reset in the middle of the sequence and checks that the whole pause starts again, which a design that kept its counter or step position across the reset would fail.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command pin levels {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REFR  = 4'b0001,
        CMD_PRECH = 4'b0010,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    // Kind of step in the initialization list
    typedef enum logic [1:0] {
        STEP_PRECH,
        STEP_REFR,
        STEP_MODE,
        STEP_XMODE
    } step_kind_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_GAP,
        PH_READY
    } phase_e;

endpackage

// File: rtl/sdram_init_plan.sv
module sdram_init_plan
    import sdram_init_pkg::*;
#(
    parameter int NUM_REFRESH   = 2,
    parameter bit REFRESH_FIRST = 1'b0,
    parameter int T_RP          = 3,
    parameter int T_RC          = 8,
    parameter int T_MRD         = 2,
    parameter int STEP_W        = 3,
    parameter int CNT_W         = 16
) (
    input  logic [STEP_W-1:0] step,
    output step_kind_e        kind,
    output logic [CNT_W-1:0]  gap
);

    // Step list: 0 is always the precharge; the placement of the refresh
    // group relative to the two mode loads is chosen at elaboration.
    generate
        if (REFRESH_FIRST) begin : g_refresh_first
            always_comb begin
                if (step == '0)
                    kind = STEP_PRECH;
                else if (step <= STEP_W'(NUM_REFRESH))
                    kind = STEP_REFR;
                else if (step == STEP_W'(NUM_REFRESH + 1))
                    kind = STEP_MODE;
                else
                    kind = STEP_XMODE;
            end
        end else begin : g_mode_first
            always_comb begin
                if (step == '0)
                    kind = STEP_PRECH;
                else if (step == STEP_W'(1))
                    kind = STEP_MODE;
                else if (step == STEP_W'(2))
                    kind = STEP_XMODE;
                else
                    kind = STEP_REFR;
            end
        end
    endgenerate

    always_comb begin
        unique case (kind)
            STEP_PRECH: gap = CNT_W'(T_RP);
            STEP_REFR:  gap = CNT_W'(T_RC);
            default:    gap = CNT_W'(T_MRD);
        endcase
    end

endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
    import sdram_init_pkg::*;
#(
    parameter int          ADDR_W       = 13,
    parameter int          BA_W         = 2,
    parameter int          AP_BIT       = 10,
    parameter logic [31:0] MODE_VAL     = 32'h0033,
    parameter logic [31:0] EXT_MODE_VAL = 32'h0000,
    parameter int          EXT_BA       = 2
) (
    input  logic              issue,
    input  step_kind_e        kind,
    output sd_cmd_e           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        if (issue) begin
            unique case (kind)
                STEP_PRECH: begin
                    cmd          = CMD_PRECH;
                    addr[AP_BIT] = 1'b1;
                end
                STEP_REFR: cmd = CMD_REFR;
                STEP_MODE: begin
                    cmd  = CMD_MODE;
                    addr = MODE_VAL[ADDR_W-1:0];
                end
                default: begin
                    cmd  = CMD_MODE;
                    addr = EXT_MODE_VAL[ADDR_W-1:0];
                    ba   = BA_W'(EXT_BA);
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int          CLK_MHZ       = 100,
    parameter int          WAIT_US       = 200,
    parameter int          T_RP          = 3,
    parameter int          T_RC          = 8,
    parameter int          T_MRD         = 2,
    parameter int          NUM_REFRESH   = 2,
    parameter bit          REFRESH_FIRST = 1'b0,
    parameter int          ADDR_W        = 13,
    parameter int          BA_W          = 2,
    parameter int          AP_BIT        = 10,
    parameter int          EXT_BA        = 2,
    parameter logic [31:0] MODE_VAL      = 32'h0033,
    parameter logic [31:0] EXT_MODE_VAL  = 32'h0000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              init_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);

    localparam int PWR_CYC = CLK_MHZ * WAIT_US;
    localparam int NSTEP   = NUM_REFRESH + 3;
    localparam int STEP_W  = $clog2(NSTEP + 1);
    localparam int MAX_A   = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_B   = (MAX_A > T_MRD) ? MAX_A : T_MRD;
    localparam int CNT_MAX = (PWR_CYC > MAX_B) ? PWR_CYC : MAX_B;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  gap;
        logic [STEP_W-1:0] step;
        logic              cke;
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase: PH_PAUSE,
        cnt:   '0,
        gap:   '0,
        step:  '0,
        cke:   1'b0,
        cmd:   CMD_NOP,
        addr:  '0,
        ba:    '0,
        done:  1'b0
    };

    seq_t seq_d, seq_q;

    step_kind_e        cur_kind;
    logic [CNT_W-1:0]  cur_gap;
    logic              issue;
    sd_cmd_e           drv_cmd;
    logic [ADDR_W-1:0] drv_addr;
    logic [BA_W-1:0]   drv_ba;

    sdram_init_plan #(
        .NUM_REFRESH  (NUM_REFRESH),
        .REFRESH_FIRST(REFRESH_FIRST),
        .T_RP         (T_RP),
        .T_RC         (T_RC),
        .T_MRD        (T_MRD),
        .STEP_W       (STEP_W),
        .CNT_W        (CNT_W)
    ) u_plan (
        .step(seq_q.step),
        .kind(cur_kind),
        .gap (cur_gap)
    );

    sdram_init_drive #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .AP_BIT      (AP_BIT),
        .MODE_VAL    (MODE_VAL),
        .EXT_MODE_VAL(EXT_MODE_VAL),
        .EXT_BA      (EXT_BA)
    ) u_drive (
        .issue(issue),
        .kind (cur_kind),
        .cmd  (drv_cmd),
        .addr (drv_addr),
        .ba   (drv_ba)
    );

    // A command goes out when the pause ends, or when a gap ends and
    // steps remain in the list.
    always_comb begin
        issue = 1'b0;
        unique case (seq_q.phase)
            PH_PAUSE: issue = (seq_q.cnt == CNT_W'(PWR_CYC - 1));
            PH_GAP:   issue = (seq_q.cnt == seq_q.gap - CNT_W'(1)) &&
                              (seq_q.step != STEP_W'(NSTEP));
            default:  issue = 1'b0;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.cke  = 1'b1;
        seq_d.cmd  = drv_cmd;
        seq_d.addr = drv_addr;
        seq_d.ba   = drv_ba;
        unique case (seq_q.phase)
            PH_PAUSE: begin
                seq_d.cnt = seq_q.cnt + CNT_W'(1);
            end
            PH_GAP: begin
                seq_d.cnt = seq_q.cnt + CNT_W'(1);
                if (seq_q.cnt == seq_q.gap - CNT_W'(1) &&
                    seq_q.step == STEP_W'(NSTEP)) begin
                    seq_d.phase = PH_READY;
                    seq_d.done  = 1'b1;
                end
            end
            default: begin
                seq_d.cnt = seq_q.cnt;
            end
        endcase
        if (issue) begin
            seq_d.phase = PH_GAP;
            seq_d.cnt   = '0;
            seq_d.gap   = cur_gap;
            seq_d.step  = seq_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign init_done = seq_q.done;
    assign sd_cke    = seq_q.cke;
    assign sd_cs_n   = seq_q.cmd[3];
    assign sd_ras_n  = seq_q.cmd[2];
    assign sd_cas_n  = seq_q.cmd[1];
    assign sd_we_n   = seq_q.cmd[0];
    assign sd_addr   = seq_q.addr;
    assign sd_ba     = seq_q.ba;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int NUM_REFRESH = 2,
    parameter int BA_W        = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            init_done,
    input logic            sd_cke,
    input logic            sd_cs_n,
    input logic            sd_ras_n,
    input logic            sd_cas_n,
    input logic            sd_we_n,
    input logic [BA_W-1:0] sd_ba
);

    logic [3:0] pins;
    logic       is_nop, is_mode, is_prech, is_refr;
    logic       prech_seen_q;
    logic [7:0] refr_cnt_q;

    assign pins     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop   = (pins == 4'b0111);
    assign is_mode  = (pins == 4'b0000);
    assign is_prech = (pins == 4'b0010);
    assign is_refr  = (pins == 4'b0001);

    always_ff @(posedge clk) begin
        if (rst) begin
            prech_seen_q <= 1'b0;
            refr_cnt_q   <= '0;
        end else begin
            if (is_prech) prech_seen_q <= 1'b1;
            if (is_refr)  refr_cnt_q   <= refr_cnt_q + 8'd1;
        end
    end

    AST_CKE_STAYS: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke); // R2
    AST_CMD_AFTER_CKE: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> $past(sd_cke)); // R2
    AST_MODE_AFTER_PRECH: assert property (@(posedge clk) disable iff (rst)
        is_mode |-> prech_seen_q); // R4
    AST_MODE_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
        is_mode |=> is_nop); // R7
    AST_REFR_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (refr_cnt_q == 8'(NUM_REFRESH))); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop); // R8

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .NUM_REFRESH(NUM_REFRESH),
    .BA_W       (BA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .init_done(init_done),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_ba    (sd_ba)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int PWR        = 20;  // CLK_MHZ=1 * WAIT_US=20
    localparam int DONE_CYC   = 39;
    localparam logic [12:0] MODE_V = 13'h0033;
    localparam logic [12:0] EXT_V  = 13'h0020;

    typedef struct packed {
        logic        inst;
        logic [7:0]  cyc;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
    } vec_t;

    // Expected non-NOP commands, per instance (0: mode first, 1: refresh first)
    localparam vec_t TBL [10] = '{
        '{1'b0, 8'd20, 4'b0010, 2'd0, 13'h0400},
        '{1'b0, 8'd23, 4'b0000, 2'd0, MODE_V},
        '{1'b0, 8'd25, 4'b0000, 2'd2, EXT_V},
        '{1'b0, 8'd27, 4'b0001, 2'd0, 13'h0000},
        '{1'b0, 8'd33, 4'b0001, 2'd0, 13'h0000},
        '{1'b1, 8'd20, 4'b0010, 2'd0, 13'h0400},
        '{1'b1, 8'd23, 4'b0001, 2'd0, 13'h0000},
        '{1'b1, 8'd29, 4'b0001, 2'd0, 13'h0000},
        '{1'b1, 8'd35, 4'b0000, 2'd0, MODE_V},
        '{1'b1, 8'd37, 4'b0000, 2'd2, EXT_V}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   ecnt;
    int   checks = 0;
    int   errors = 0;

    logic              done_w [2];
    logic              cke_w  [2];
    logic [3:0]        cmd_w  [2];
    logic [ADDR_W-1:0] addr_w [2];
    logic [BA_W-1:0]   ba_w   [2];
    logic c0, r0, a0, w0, c1, r1, a1, w1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

    sdram_init_seq #(
        .CLK_MHZ(1), .WAIT_US(20), .T_RP(3), .T_RC(6), .T_MRD(2),
        .NUM_REFRESH(2), .REFRESH_FIRST(1'b0),
        .MODE_VAL({19'd0, MODE_V}), .EXT_MODE_VAL({19'd0, EXT_V})
    ) u0 (
        .clk(clk), .rst(rst), .init_done(done_w[0]), .sd_cke(cke_w[0]),
        .sd_cs_n(c0), .sd_ras_n(r0), .sd_cas_n(a0), .sd_we_n(w0),
        .sd_addr(addr_w[0]), .sd_ba(ba_w[0])
    );

    sdram_init_seq #(
        .CLK_MHZ(1), .WAIT_US(20), .T_RP(3), .T_RC(6), .T_MRD(2),
        .NUM_REFRESH(2), .REFRESH_FIRST(1'b1),
        .MODE_VAL({19'd0, MODE_V}), .EXT_MODE_VAL({19'd0, EXT_V})
    ) u1 (
        .clk(clk), .rst(rst), .init_done(done_w[1]), .sd_cke(cke_w[1]),
        .sd_cs_n(c1), .sd_ras_n(r1), .sd_cas_n(a1), .sd_we_n(w1),
        .sd_addr(addr_w[1]), .sd_ba(ba_w[1])
    );

    assign cmd_w[0] = {c0, r0, a0, w0};
    assign cmd_w[1] = {c1, r1, a1, w1};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, ecnt, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(cke_w[i] == 1'b0, tag, "cke", int'(cke_w[i]), 0);
            chk(cmd_w[i] == 4'b0111, tag, "cmd", int'(cmd_w[i]), 7);
            chk(addr_w[i] == '0 && ba_w[i] == '0, tag, "addr/ba",
                int'({ba_w[i], addr_w[i]}), 0);
            chk(done_w[i] == 1'b0, tag, "done", int'(done_w[i]), 0);
        end
    endtask

    // Walk cycles 1..last, comparing each instance against the table
    task automatic walk(input int last);
        for (int c = 1; c <= last; c++) begin
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                logic [3:0]  ecmd = 4'b0111;
                logic [1:0]  eba  = 2'd0;
                logic [12:0] ead  = 13'd0;
                string       tag  = "R7";
                for (int k = 0; k < 10; k++) begin
                    if (TBL[k].inst == 1'(i) && int'(TBL[k].cyc) == c) begin
                        ecmd = TBL[k].cmd;
                        eba  = TBL[k].ba;
                        ead  = TBL[k].addr;
                        if (i == 1 && c > 20)       tag = "R6";
                        else if (ecmd == 4'b0010)   tag = "R3";
                        else if (ecmd == 4'b0001)   tag = "R5";
                        else                        tag = "R4";
                    end
                end
                if (c < PWR) tag = "R3";
                chk(cmd_w[i] == ecmd, tag, "cmd", int'(cmd_w[i]), int'(ecmd));
                chk(ba_w[i] == eba, tag, "ba", int'(ba_w[i]), int'(eba));
                chk(addr_w[i] == ead, tag, "addr", int'(addr_w[i]), int'(ead));
                chk(cke_w[i] == 1'b1, "R2", "cke", int'(cke_w[i]), 1);
                chk(done_w[i] == (c >= DONE_CYC), "R8", "done",
                    int'(done_w[i]), int'(c >= DONE_CYC));
            end
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", ecnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk_reset_state("R1");

        // Full run from reset, including a tail after done (R8 hold)
        rst = 1'b0;
        walk(DONE_CYC + 15);

        // Mid-sequence reset, then a complete repeat (R9)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_reset_state("R9");
        rst = 1'b0;
        walk(24);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_reset_state("R9");
        rst = 1'b0;
        walk(DONE_CYC + 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule